// File: doc/BRIEF.md
# Bottom-Origin Monochrome Raster Fetch Address Generator

This block drives the scan of a 1024 by 768, one-bit-per-pixel bitmap kept in a memory that is addressed in 32-bit words. In the pixel clock domain it runs a horizontal position counter and a vertical line counter, both of which also cover the blanking intervals. From these counts it produces registered data-enable, horizontal sync and vertical sync outputs. In the memory clock domain it captures the word index within the current line, which is the group of 32 pixels, together with the line count. It then forms the word address of the next fetch.

Software treats the bitmap with its origin in the lower-left corner, while the monitor scans from the top-left. To reconcile the two, the line count is bit-inverted before it is placed into the address, on top of a fixed origin constant. The top monitor line therefore sits at the highest line address and the bottom line at the lowest, with no subtractor in the path. Each line takes a stride of 32 words (128 bytes). The memory array and the pixel serializer are not part of this block.

Top module: `fbscan_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, both counters clear to zero. At that edge `de_o` goes low, both sync outputs go to their inactive level and the captured line and index go to zero, so `fetch_addr` reads 0x3FFA0. After release the scan restarts at position 0, line 0.
- R2: The horizontal count runs from 0 to `H_TOTAL-1` and then wraps to 0. The line count advances by one only on that wrap, and it wraps to 0 after line `V_TOTAL-1`. At the frame wrap, both counts wrap in the same cycle.
- R3: `de_o` is high exactly when the position is below `H_ACTIVE` and the line is below `V_ACTIVE`.
- R4: The word index is bits [9:5] of the horizontal count, that is, the position divided by 32. It keeps following the count during horizontal blanking.
- R5: The word address is `ORIGIN + {3'b000, ~line[9:0], index[4:0]}` with `ORIGIN` = 0x37FC0 (byte 0xDFF00). Equivalently, it is 0x3FFA0 - 32*line + index.
- R6: Line 0, word 0 is at word address 0x3FFA0 (byte 0xFFE80). Line 767, word 0 is at 0x39FC0 (byte 0xE7F00). Each further line lies 32 words lower.
- R7: `hsync_o` is at its active level exactly while the position lies in [`H_SYNC_START`, `H_SYNC_END`). The active level is low when `SYNC_ACTIVE_HIGH` is 0, which is the default, and high otherwise.
- R8: `vsync_o` is at its active level, with the same polarity rule, for every position of every line in [`V_SYNC_START`, `V_SYNC_END`).
- R9: With both clocks tied together, `de_o`, the syncs and `fetch_addr` appear one clock after the counter state they describe, and all of them are aligned to the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock; the counters and the raster flags run on it |
| mem_clk | input | 1 | Memory clock; the index and line capture run on it |
| rst_n | input | 1 | Synchronous active-low reset, applied in both domains |
| de_o | output | 1 | High while the registered position is inside the visible area |
| hsync_o | output | 1 | Horizontal sync pulse with polarity set by parameter |
| vsync_o | output | 1 | Vertical sync pulse with polarity set by parameter |
| fetch_addr | output | 18 | Word address of the 32-pixel group to fetch |

## Verification
The scan can reach its last position on the last line, so the horizontal wrap and the line wrap to line 0 fall in the same cycle. In that cycle the address must jump upward from the bottom-most line back to 0x3FFA0 while `de_o` rises. The bench provokes this by shrinking the horizontal total while keeping all 768 visible lines and running past one full frame. It then judges every cycle on both sides of the boundary against a scoreboard computed from the arithmetic form of R5. A reset applied in the middle of a frame also checks that a forced restart and the natural wrap produce the same first-cycle output.

// File: rtl/fbscan_pkg.sv
// Package: fbscan_pkg
// Shared widths and the address-forming function for the raster fetch
// generator. The widths are set by the memory layout: a 1 MB word-addressed
// store, a 1024-pixel line stride and a 10-bit line count.
package fbscan_pkg;
    localparam int HCNT_W  = 11;   // horizontal count incl. retrace
    localparam int VCNT_W  = 10;   // line count
    localparam int IDX_W   = 5;    // word index within a line
    localparam int IDX_LSB = 5;    // 32 pixels per word
    localparam int ADDR_W  = 18;   // 256K words = 1 MB
    localparam int PAD_W   = ADDR_W - VCNT_W - IDX_W;

    localparam logic [ADDR_W-1:0] ORIGIN_DEFAULT = 18'h37FC0; // byte 0xDFF00

    // Forms the fetch word address: origin plus inverted line and index.
    function automatic logic [ADDR_W-1:0] form_addr(
        input logic [ADDR_W-1:0] origin,
        input logic [VCNT_W-1:0] line,
        input logic [IDX_W-1:0]  idx
    );
        return origin + {{PAD_W{1'b0}}, ~line, idx};
    endfunction
endpackage

// File: rtl/fbscan_counter.sv
// Module: fbscan_counter
// Wrapping up-counter from 0 to LIMIT-1, advancing when en is high.
// Assumes LIMIT >= 2 and LIMIT <= 2**W. Synchronous active-low reset.
module fbscan_counter #(
    parameter int W     = 11,
    parameter int LIMIT = 1344
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] cnt,
    output logic         at_last
);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    // Flags the final count of the cycle.
    assign at_last = (cnt == LAST);

    // Advances the count, wrapping after LAST.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fbscan_window.sv
// Module: fbscan_window
// Registered pulse that is active while cnt lies in [START, STOP).
// ACTIVE_HIGH selects the output polarity. Assumes START < STOP <= 2**W.
// Resets to the inactive level.
module fbscan_window #(
    parameter int W           = 11,
    parameter int START       = 1048,
    parameter int STOP        = 1184,
    parameter bit ACTIVE_HIGH = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    output logic         pulse
);
    localparam logic [W-1:0] S_POS = W'(START);
    localparam logic [W-1:0] E_POS = W'(STOP);

    logic in_win;

    // Decodes whether the current count is inside the pulse window.
    assign in_win = (cnt >= S_POS) && (cnt < E_POS);

    generate
        if (ACTIVE_HIGH) begin : g_pos
            // Drives a high-true pulse.
            always_ff @(posedge clk) begin
                if (!rst_n) pulse <= 1'b0;
                else        pulse <= in_win;
            end
        end else begin : g_neg
            // Drives a low-true pulse.
            always_ff @(posedge clk) begin
                if (!rst_n) pulse <= 1'b1;
                else        pulse <= ~in_win;
            end
        end
    endgenerate
endmodule

// File: rtl/fbscan_memaddr.sv
// Module: fbscan_memaddr
// Memory-domain side: captures the word index and the line count from the
// pixel domain and forms the fetch word address. It assumes the two clocks
// are related, or that the consumer tolerates a sample taken mid-change of
// the index, as a scan-out fetch does.
module fbscan_memaddr
    import fbscan_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ORIGIN = ORIGIN_DEFAULT
) (
    input  logic              mem_clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  pix_idx,
    input  logic [VCNT_W-1:0] pix_line,
    output logic [VCNT_W-1:0] line_q,
    output logic [ADDR_W-1:0] fetch_addr
);
    logic [IDX_W-1:0] idx_q;

    // Captures the index and line in the memory clock domain.
    always_ff @(posedge mem_clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            line_q <= '0;
        end else begin
            idx_q  <= pix_idx;
            line_q <= pix_line;
        end
    end

    // Combines the origin, the inverted line and the index.
    assign fetch_addr = form_addr(ORIGIN, line_q, idx_q);
endmodule

// File: rtl/fbscan_addr_gen.sv
// Module: fbscan_addr_gen
// Top level of the raster fetch generator. It runs the horizontal and
// vertical counters on pix_clk, registers the data-enable and sync flags,
// and hands the word index and line to the memory domain for address
// forming. All timing values are parameters. The visible width must not
// exceed 1024 and the totals must fit the counter widths.
module fbscan_addr_gen
    import fbscan_pkg::*;
#(
    parameter int H_ACTIVE         = 1024,
    parameter int H_TOTAL          = 1344,
    parameter int H_SYNC_START     = 1048,
    parameter int H_SYNC_END       = 1184,
    parameter int V_ACTIVE         = 768,
    parameter int V_TOTAL          = 806,
    parameter int V_SYNC_START     = 771,
    parameter int V_SYNC_END       = 777,
    parameter bit SYNC_ACTIVE_HIGH = 1'b0,
    parameter logic [ADDR_W-1:0] ORIGIN = ORIGIN_DEFAULT
) (
    input  logic              pix_clk,
    input  logic              mem_clk,
    input  logic              rst_n,
    output logic              de_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic [ADDR_W-1:0] fetch_addr
);
    localparam logic [HCNT_W-1:0] H_VIS = HCNT_W'(H_ACTIVE);
    localparam logic [VCNT_W-1:0] V_VIS = VCNT_W'(V_ACTIVE);

    logic [HCNT_W-1:0] h_cnt;
    logic [VCNT_W-1:0] v_cnt;
    logic              h_last;
    logic              v_last;
    logic [VCNT_W-1:0] line_q;

    fbscan_counter #(.W(HCNT_W), .LIMIT(H_TOTAL)) u_hcnt (
        .clk     (pix_clk),
        .rst_n   (rst_n),
        .en      (1'b1),
        .cnt     (h_cnt),
        .at_last (h_last)
    );

    fbscan_counter #(.W(VCNT_W), .LIMIT(V_TOTAL)) u_vcnt (
        .clk     (pix_clk),
        .rst_n   (rst_n),
        .en      (h_last),
        .cnt     (v_cnt),
        .at_last (v_last)
    );

    fbscan_window #(
        .W(HCNT_W), .START(H_SYNC_START), .STOP(H_SYNC_END),
        .ACTIVE_HIGH(SYNC_ACTIVE_HIGH)
    ) u_hsync (
        .clk   (pix_clk),
        .rst_n (rst_n),
        .cnt   (h_cnt),
        .pulse (hsync_o)
    );

    fbscan_window #(
        .W(VCNT_W), .START(V_SYNC_START), .STOP(V_SYNC_END),
        .ACTIVE_HIGH(SYNC_ACTIVE_HIGH)
    ) u_vsync (
        .clk   (pix_clk),
        .rst_n (rst_n),
        .cnt   (v_cnt),
        .pulse (vsync_o)
    );

    // Registers the visible-area flag alongside the syncs.
    always_ff @(posedge pix_clk) begin
        if (!rst_n) de_o <= 1'b0;
        else        de_o <= (h_cnt < H_VIS) && (v_cnt < V_VIS);
    end

    fbscan_memaddr #(.ORIGIN(ORIGIN)) u_addr (
        .mem_clk    (mem_clk),
        .rst_n      (rst_n),
        .pix_idx    (h_cnt[IDX_LSB+IDX_W-1:IDX_LSB]),
        .pix_line   (v_cnt),
        .line_q     (line_q),
        .fetch_addr (fetch_addr)
    );
endmodule

// File: rtl/fbscan_checker.sv
// Module: fbscan_checker
// Property checker bound to fbscan_addr_gen. It observes the counters, the
// registered flags and the captured line. The timing parameters are passed
// through the bind statement below.
module fbscan_checker
    import fbscan_pkg::*;
#(
    parameter int H_ACTIVE         = 1024,
    parameter int H_TOTAL          = 1344,
    parameter int H_SYNC_START     = 1048,
    parameter int H_SYNC_END       = 1184,
    parameter int V_ACTIVE         = 768,
    parameter bit SYNC_ACTIVE_HIGH = 1'b0
) (
    input logic              pix_clk,
    input logic              mem_clk,
    input logic              rst_n,
    input logic [HCNT_W-1:0] hcnt,
    input logic [VCNT_W-1:0] vcnt,
    input logic              de,
    input logic              hsync,
    input logic [VCNT_W-1:0] line_q,
    input logic [ADDR_W-1:0] fetch_addr
);
    localparam logic [HCNT_W-1:0] H_LAST = HCNT_W'(H_TOTAL - 1);
    localparam logic [HCNT_W-1:0] H_VIS  = HCNT_W'(H_ACTIVE);
    localparam logic [VCNT_W-1:0] V_VIS  = VCNT_W'(V_ACTIVE);
    localparam logic [HCNT_W-1:0] HS_S   = HCNT_W'(H_SYNC_START);
    localparam logic [HCNT_W-1:0] HS_E   = HCNT_W'(H_SYNC_END);
    localparam logic              ACT    = SYNC_ACTIVE_HIGH;

    // R2: the horizontal count returns to zero after its last value.
    a_r2_h_wrap: assert property (@(posedge pix_clk) disable iff (!rst_n)
        (hcnt == H_LAST) |=> (hcnt == '0));

    // R2: the line count holds except on the horizontal wrap.
    a_r2_v_hold: assert property (@(posedge pix_clk) disable iff (!rst_n)
        (hcnt != H_LAST) |=> $stable(vcnt));

    // R3: data enable only follows a visible position.
    a_r3_de_window: assert property (@(posedge pix_clk) disable iff (!rst_n)
        de |-> ($past(hcnt) < H_VIS) && ($past(vcnt) < V_VIS));

    // R7: an active horizontal sync only follows a position in the window.
    a_r7_hsync_window: assert property (@(posedge pix_clk) disable iff (!rst_n)
        (hsync == ACT) |-> ($past(hcnt) >= HS_S) && ($past(hcnt) < HS_E));

    // R6: moving to a later nonzero line lowers the fetch address.
    a_r6_line_descends: assert property (@(posedge mem_clk) disable iff (!rst_n)
        ((line_q != $past(line_q)) && (line_q != '0)) |->
        (fetch_addr < $past(fetch_addr)));
endmodule

bind fbscan_addr_gen fbscan_checker #(
    .H_ACTIVE         (H_ACTIVE),
    .H_TOTAL          (H_TOTAL),
    .H_SYNC_START     (H_SYNC_START),
    .H_SYNC_END       (H_SYNC_END),
    .V_ACTIVE         (V_ACTIVE),
    .SYNC_ACTIVE_HIGH (SYNC_ACTIVE_HIGH)
) u_chk (
    .pix_clk    (pix_clk),
    .mem_clk    (mem_clk),
    .rst_n      (rst_n),
    .hcnt       (h_cnt),
    .vcnt       (v_cnt),
    .de         (de_o),
    .hsync      (hsync_o),
    .line_q     (line_q),
    .fetch_addr (fetch_addr)
);

// File: tb/tb_fbscan_addr_gen.sv
// Scoreboard bench: a driver task pushes the expected output for each scan
// position and a monitor pops and compares it at the falling edge.
`timescale 1ns/1ps
module tb_fbscan_addr_gen;
    localparam int HA  = 96;
    localparam int HT  = 112;
    localparam int HSS = 100;
    localparam int HSE = 108;
    localparam int VA  = 768;
    localparam int VT  = 772;
    localparam int VSS = 769;
    localparam int VSE = 771;

    typedef struct {
        int          n;
        logic        de;
        logic        hs;
        logic        vs;
        logic [17:0] addr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        de_o, hsync_o, vsync_o;
    logic [17:0] fetch_addr;

    int   tests = 0;
    int   fails = 0;
    bit   done  = 1'b0;
    int   n_pos = 0;
    exp_t q[$];

    always #2 clk = ~clk;   // 250 MHz

    fbscan_addr_gen #(
        .H_ACTIVE(HA), .H_TOTAL(HT), .H_SYNC_START(HSS), .H_SYNC_END(HSE),
        .V_ACTIVE(VA), .V_TOTAL(VT), .V_SYNC_START(VSS), .V_SYNC_END(VSE)
    ) dut (
        .pix_clk    (clk),
        .mem_clk    (clk),
        .rst_n      (rst_n),
        .de_o       (de_o),
        .hsync_o    (hsync_o),
        .vsync_o    (vsync_o),
        .fetch_addr (fetch_addr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Expected output for scan position n, from the requirement arithmetic.
    function automatic exp_t model(input int n);
        exp_t e;
        int h, v;
        h = n % HT;
        v = (n / HT) % VT;
        e.n    = n;
        e.de   = (h < HA) && (v < VA);
        e.hs   = !((h >= HSS) && (h < HSE));   // active low
        e.vs   = !((v >= VSS) && (v < VSE));
        e.addr = 18'(32'h3FFA0 - 32 * v + h / 32);
        return e;
    endfunction

    // Driver: one expected item per rising edge after reset release.
    task automatic run_cycles(input int count);
        for (int i = 0; i < count; i++) begin
            @(posedge clk);
            #1;
            q.push_back(model(n_pos));
            n_pos++;
        end
    endtask

    // Monitor: pops and compares at the falling edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check("R3", "de", 32'(de_o), 32'(e.de));
            check("R7", "hsync", 32'(hsync_o), 32'(e.hs));
            check("R8", "vsync", 32'(vsync_o), 32'(e.vs));
            check("R5 R9", "fetch_addr", 32'(fetch_addr), 32'(e.addr));
            if (e.n == 0)
                check("R6", "line 0 word 0", 32'(fetch_addr), 32'h3FFA0);
            if (e.n == 767 * HT)
                check("R6", "line 767 word 0", 32'(fetch_addr), 32'h39FC0);
            if (e.n == 2 * HT)
                check("R6", "line 2 stride", 32'(fetch_addr), 32'h3FF60);
            if (e.n == 95)
                check("R4", "index at pixel 95", 32'(fetch_addr), 32'h3FFA2);
            if (e.n == HSS)
                check("R4", "index in blanking", 32'(fetch_addr), 32'h3FFA3);
            if (e.n == VT * HT - 1)
                check("R2", "last position de", 32'(de_o), 32'd0);
            if (e.n == VT * HT) begin
                check("R2", "frame wrap de", 32'(de_o), 32'd1);
                check("R2", "frame wrap addr", 32'(fetch_addr), 32'h3FFA0);
            end
        end
    end

    task automatic check_reset_state();
        check("R1", "reset de", 32'(de_o), 32'd0);
        check("R1", "reset hsync", 32'(hsync_o), 32'd1);
        check("R1", "reset vsync", 32'(vsync_o), 32'd1);
        check("R1", "reset addr", 32'(fetch_addr), 32'h3FFA0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        n_pos = 0;
        run_cycles(3000);

        // Mid-frame reset, then restart from position 0 (R1).
        @(negedge clk);
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        n_pos = 0;
        run_cycles(VT * HT + 3 * HT);
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule